// File: doc/BRIEF.md
# Multi-Sequence Program Counter Scheduler

This block keeps a separate program counter for each of a fixed set of instruction sequences and decides which sequence issues the next instruction. Each sequence belongs to one user or attached device, and that user raises a request when the sequence needs the processor. A sequence remains pending until it gives up its own claim. After every instruction the choice is made again. The pending sequence with the highest number wins, so a more urgent sequence takes over at the next instruction boundary. The sequence it displaced keeps its counter and resumes later from the same place.

The execution unit reports each finished instruction with a one-cycle strobe. With that strobe it says whether the running counter advances by one or takes a jump target, and whether the running sequence gives up its request. One cycle later the block presents the number of the chosen sequence and its counter value. Sequence 0 is always eligible and acts as the background program. A side port can preload the counter of any sequence that is not currently running.

Top module: `mseq_sched`

## Requirements
- R1: After reset, `cur_sel` is 0, `cur_pc` is 0, every stored counter is 0, and only sequence 0 is pending.
- R2: On a cycle with `done` high, the next `cur_sel` is the highest-numbered pending sequence, where a sequence counts as pending if it was pending before or if its `req_set` bit is high in that cycle. Sequence 31 ranks above sequence 0.
- R3: While `done` is low, `cur_sel` and `cur_pc` keep their values, even when requests or loads arrive.
- R4: Sequence 0 is always pending. A dismiss issued while sequence 0 runs has no effect, and sequence 0 is chosen whenever no other sequence is pending.
- R5: On `done` with `upd_jump` = 0, the counter of the running sequence advances by one and wraps from 0xFFFF to 0x0000. If that sequence is chosen again, `cur_pc` shows the advanced value.
- R6: On `done` with `upd_jump` = 1, the counter of the running sequence takes `upd_target`.
- R7: On `done` with `dismiss` = 1, the running sequence stops being pending. If its own `req_set` bit is high in the same cycle, the request wins and the sequence stays pending.
- R8: A sequence that was displaced or dismissed keeps its updated counter. When it is chosen again, `cur_pc` resumes from that value.
- R9: With `ld_en` high, `ld_val` is written into the counter numbered `ld_idx`, provided `ld_idx` is not `cur_sel`. A load aimed at the running sequence is ignored.
- R10: A load in the same cycle as a `done` that selects sequence `ld_idx` appears at once in the new `cur_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_set | input | NSEQ | One bit per sequence; a high bit marks that sequence pending |
| done | input | 1 | Strobe marking the end of the running instruction |
| dismiss | input | 1 | With `done`: the running sequence gives up its request |
| upd_jump | input | 1 | With `done`: 0 advances the counter, 1 loads `upd_target` |
| upd_target | input | PCW | Jump target for the running counter |
| ld_en | input | 1 | Direct counter load enable |
| ld_idx | input | SELW | Sequence whose counter is loaded |
| ld_val | input | PCW | Value to load |
| cur_sel | output | SELW | Registered number of the sequence chosen to issue |
| cur_pc | output | PCW | Registered counter value of the chosen sequence |

## Verification
The assertions run on every cycle and cover the invariants that hold at each clock: sequence 0 is always pending, the chosen sequence is pending with nothing pending above it after each strobe, both outputs hold between strobes, and a sequence that is chosen again shows its advanced or jumped counter. Some behaviours only show up across a sequence of instructions, so the bench's scenarios cover them. These include a displaced sequence resuming from its saved counter, a whole cascade of dismissals working down the priority order, a load being ignored or forwarded depending on which sequence runs, the request-versus-dismiss collision, and counter wrap.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef enum logic [0:0] {
    PC_STEP = 1'b0,
    PC_JUMP = 1'b1
  } pc_op_e;
endpackage

// File: rtl/mseq_pick.sv
// Highest-numbered set bit wins.
module mseq_pick #(
  parameter int NSEQ = 32,
  parameter int SELW = $clog2(NSEQ)
) (
  input  logic [NSEQ-1:0] vec,
  output logic [SELW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NSEQ; i++) begin
      if (vec[i]) idx = SELW'(i);
    end
  end
endmodule

// File: rtl/mseq_reqs.sv
// Per-sequence pending flags; bit 0 is pinned high.
module mseq_reqs #(
  parameter int NSEQ = 32,
  parameter int SELW = $clog2(NSEQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEQ-1:0] req_set,
  input  logic            done,
  input  logic            dismiss,
  input  logic [SELW-1:0] run_idx,
  output logic [NSEQ-1:0] pend_q,
  output logic [NSEQ-1:0] pend_n
);
  genvar g;
  generate
    for (g = 0; g < NSEQ; g++) begin : g_flag
      if (g == 0) begin : g_bg
        assign pend_n[g] = 1'b1;
      end else begin : g_fg
        logic drop;
        assign drop      = done && dismiss && (run_idx == SELW'(g));
        assign pend_n[g] = req_set[g] | (pend_q[g] & ~drop);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pend_q <= NSEQ'(1);
    else     pend_q <= pend_n;
  end
endmodule

// File: rtl/mseq_pcbank.sv
// Parked program counters: one write-back port, one load port, async read.
module mseq_pcbank #(
  parameter int NSEQ = 32,
  parameter int SELW = $clog2(NSEQ),
  parameter int PCW  = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wb_en,
  input  logic [SELW-1:0] wb_idx,
  input  logic [PCW-1:0]  wb_val,
  input  logic            ld_en,
  input  logic [SELW-1:0] ld_idx,
  input  logic [PCW-1:0]  ld_val,
  input  logic [SELW-1:0] rd_idx,
  output logic [PCW-1:0]  rd_val
);
  logic [PCW-1:0] mem [NSEQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEQ; i++) mem[i] <= '0;
    end else begin
      if (ld_en) mem[ld_idx] <= ld_val;
      if (wb_en) mem[wb_idx] <= wb_val;
    end
  end

  assign rd_val = mem[rd_idx];
endmodule

// File: rtl/mseq_sched.sv
module mseq_sched #(
  parameter int NSEQ = 32,
  parameter int PCW  = 16,
  parameter int SELW = $clog2(NSEQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEQ-1:0] req_set,
  input  logic            done,
  input  logic            dismiss,
  input  logic            upd_jump,
  input  logic [PCW-1:0]  upd_target,
  input  logic            ld_en,
  input  logic [SELW-1:0] ld_idx,
  input  logic [PCW-1:0]  ld_val,
  output logic [SELW-1:0] cur_sel,
  output logic [PCW-1:0]  cur_pc
);
  import mseq_pkg::*;

  logic [NSEQ-1:0] pend_q, pend_n;
  logic [SELW-1:0] next_sel;
  logic [PCW-1:0]  run_next, parked;
  logic            ld_ok;
  pc_op_e          op;

  assign op       = pc_op_e'(upd_jump);
  assign run_next = (op == PC_JUMP) ? upd_target : cur_pc + PCW'(1);
  assign ld_ok    = ld_en && (ld_idx != cur_sel);

  mseq_reqs #(.NSEQ(NSEQ), .SELW(SELW)) reqs_i (
    .clk(clk), .rst(rst), .req_set(req_set), .done(done),
    .dismiss(dismiss), .run_idx(cur_sel), .pend_q(pend_q), .pend_n(pend_n)
  );

  mseq_pick #(.NSEQ(NSEQ), .SELW(SELW)) pick_i (
    .vec(pend_n), .idx(next_sel)
  );

  mseq_pcbank #(.NSEQ(NSEQ), .SELW(SELW), .PCW(PCW)) bank_i (
    .clk(clk), .rst(rst),
    .wb_en(done), .wb_idx(cur_sel), .wb_val(run_next),
    .ld_en(ld_ok), .ld_idx(ld_idx), .ld_val(ld_val),
    .rd_idx(next_sel), .rd_val(parked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_sel <= '0;
      cur_pc  <= '0;
    end else if (done) begin
      cur_sel <= next_sel;
      if (next_sel == cur_sel)                 cur_pc <= run_next;
      else if (ld_ok && (ld_idx == next_sel))  cur_pc <= ld_val;
      else                                     cur_pc <= parked;
    end
  end
endmodule

// File: rtl/mseq_sched_chk.sv
module mseq_sched_chk #(
  parameter int NSEQ = 32,
  parameter int PCW  = 16,
  parameter int SELW = $clog2(NSEQ)
) (
  input logic            clk,
  input logic            rst,
  input logic            done,
  input logic            dismiss,
  input logic            upd_jump,
  input logic [PCW-1:0]  upd_target,
  input logic [NSEQ-1:0] req_set,
  input logic [NSEQ-1:0] pend_q,
  input logic [SELW-1:0] cur_sel,
  input logic [PCW-1:0]  cur_pc
);
  logic stay;
  assign stay = done && !dismiss && (req_set == '0) && ((pend_q >> cur_sel) == NSEQ'(1));

  AST_BG_PENDING: assert property (@(posedge clk) disable iff (rst)
    pend_q[0]);  // R4
  AST_SEL_PENDING: assert property (@(posedge clk) disable iff (rst)
    pend_q[cur_sel]);  // R2
  AST_TOP_CHOSEN: assert property (@(posedge clk) disable iff (rst)
    done |=> ((pend_q >> cur_sel) == NSEQ'(1)));  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(cur_sel) && $stable(cur_pc)));  // R3
  AST_STEP_ADV: assert property (@(posedge clk) disable iff (rst)
    (stay && !upd_jump) |=> (cur_pc == PCW'($past(cur_pc) + PCW'(1))));  // R5
  AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (stay && upd_jump) |=> (cur_pc == $past(upd_target)));  // R6
endmodule

bind mseq_sched mseq_sched_chk #(.NSEQ(NSEQ), .PCW(PCW), .SELW(SELW)) chk_i (
  .clk(clk), .rst(rst), .done(done), .dismiss(dismiss), .upd_jump(upd_jump),
  .upd_target(upd_target), .req_set(req_set), .pend_q(pend_q),
  .cur_sel(cur_sel), .cur_pc(cur_pc)
);

// File: tb/mseq_sched_tb_top.sv
module mseq_sched_tb_top;
  localparam int NSEQ = 32;
  localparam int PCW  = 16;
  localparam int SELW = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSEQ-1:0] req_set = '0;
  logic            done = 1'b0, dismiss = 1'b0, upd_jump = 1'b0, ld_en = 1'b0;
  logic [PCW-1:0]  upd_target = '0, ld_val = '0;
  logic [SELW-1:0] ld_idx = '0;
  logic [SELW-1:0] cur_sel;
  logic [PCW-1:0]  cur_pc;

  always #5 clk = ~clk;

  mseq_sched #(.NSEQ(NSEQ), .PCW(PCW)) dut_i (
    .clk(clk), .rst(rst), .req_set(req_set), .done(done), .dismiss(dismiss),
    .upd_jump(upd_jump), .upd_target(upd_target), .ld_en(ld_en),
    .ld_idx(ld_idx), .ld_val(ld_val), .cur_sel(cur_sel), .cur_pc(cur_pc)
  );

  typedef struct {
    int sel;
    int pc;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int n_tests = 0, n_fail = 0;

  // reference state from the requirements
  logic [NSEQ-1:0] m_pend;
  logic [PCW-1:0]  m_pc [NSEQ];
  int              m_sel;

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one instruction boundary
  task automatic step(input logic [NSEQ-1:0] r, input logic dis, input logic jmp,
                      input logic [PCW-1:0] tgt, input logic le, input int li,
                      input logic [PCW-1:0] lv, input string tag);
    exp_t e;
    req_set = r; dismiss = dis; upd_jump = jmp; upd_target = tgt;
    ld_en = le; ld_idx = SELW'(li); ld_val = lv; done = 1'b1;
    if (le && li != m_sel) m_pc[li] = lv;
    m_pc[m_sel] = jmp ? tgt : m_pc[m_sel] + 16'd1;
    m_pend = m_pend | r;
    if (dis && !r[m_sel]) m_pend[m_sel] = 1'b0;
    m_pend[0] = 1'b1;
    for (int i = 0; i < NSEQ; i++) if (m_pend[i]) m_sel = i;
    e.sel = m_sel; e.pc = int'(m_pc[m_sel]); e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    @(negedge clk);
    done = 1'b0; req_set = '0; dismiss = 1'b0; upd_jump = 1'b0; ld_en = 1'b0;
  endtask

  // a cycle without an instruction boundary
  task automatic idle(input logic [NSEQ-1:0] r, input logic le, input int li,
                      input logic [PCW-1:0] lv);
    int s0, p0;
    s0 = int'(cur_sel); p0 = int'(cur_pc);
    req_set = r; ld_en = le; ld_idx = SELW'(li); ld_val = lv;
    m_pend = m_pend | r;
    if (le && li != m_sel) m_pc[li] = lv;
    @(posedge clk);
    @(negedge clk);
    req_set = '0; ld_en = 1'b0;
    check("R3 sel held", int'(cur_sel), s0);
    check("R3 pc held", int'(cur_pc), p0);
  endtask

  // monitor: compare after each strobe
  initial begin
    forever begin
      @(posedge clk);
      if (done && !rst) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check("scoreboard empty", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " sel"}, int'(cur_sel), e.sel);
          check({e.tag, " pc"}, int'(cur_pc), e.pc);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_pend = NSEQ'(1); m_sel = 0;
    for (int i = 0; i < NSEQ; i++) m_pc[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset sel", int'(cur_sel), 0);
    check("R1 reset pc", int'(cur_pc), 0);

    step('0, 0, 0, 0, 0, 0, 0, "R4 R5 background step");
    idle('0, 1, 5, 16'h0100);
    step(32'h1 << 5, 0, 0, 0, 0, 0, 0, "R2 R9 preempt to 5");
    step(32'h1 << 9, 0, 1, 16'h0200, 0, 0, 0, "R2 R6 R1 jump then preempt to 9");
    idle(32'h1 << 20, 0, 0, 0);
    step('0, 1, 0, 0, 0, 0, 0, "R7 R2 dismiss 9 to 20");
    step('0, 1, 0, 0, 0, 0, 0, "R8 resume 5");
    idle('0, 1, 5, 16'hAAAA);
    step('0, 0, 0, 0, 0, 0, 0, "R9 load to running ignored");
    step(32'h1 << 5, 1, 0, 0, 0, 0, 0, "R7 request beats dismiss");
    step('0, 1, 0, 0, 1, 0, 16'h0777, "R10 load forwarded");
    step('0, 1, 0, 0, 0, 0, 0, "R4 dismiss of 0 ignored");
    idle('0, 1, 31, 16'hFFFF);
    step(32'h1 << 31, 0, 0, 0, 0, 0, 0, "R2 R9 select 31");
    step('0, 0, 0, 0, 0, 0, 0, "R5 wrap");
    step((32'h1 << 3) | (32'h1 << 17) | (32'h1 << 30), 1, 0, 0, 0, 0, 0, "R2 cascade 30");
    step('0, 1, 0, 0, 0, 0, 0, "R2 cascade 17");
    step('0, 1, 0, 0, 0, 0, 0, "R2 cascade 3");
    step('0, 1, 0, 0, 0, 0, 0, "R4 back to 0");
    step(32'h1 << 9, 0, 0, 0, 0, 0, 0, "R8 resume 9");

    repeat (3) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule